// File: doc/BRIEF.md
# I/O Interrupt Redirection Controller

This block collects interrupt lines from peripherals and turns each active, unmasked line into a delivery message for the interrupt fabric. Every input pin owns a 64-bit redirection entry that holds the vector, the delivery mode, the destination and its interpretation, the polarity, the trigger mode and a mask bit. The downstream block decodes the destination. This block only routes; it has no end-of-interrupt feedback and no arbitration.

Software reaches the block through an indirect window on a small memory-mapped bus. An 8-bit select register sits at offset 0x00. The 32-bit data port at offset 0x10 accesses whichever register the select value points at. Each 64-bit entry appears as two 32-bit halves: an even select reaches the low half and an odd select reaches the high half. A pass of the service scanner starts after any input assertion and after any write to an entry. The scanner checks one pin per clock, from pin 0 upward. For every pending, unmasked pin it emits one message on a valid/ready handshake, and it stalls while ready is low.

Top module: `irq_router`

## Requirements
- R1: After reset every entry low half reads 0x00010000 (only mask bit 16 set), every high half reads 0, the select and ID read 0, no pin is pending and msg_valid is low.
- R2: Offset 0x00 reads and writes the 8-bit select value (zero-extended). Reads of offsets other than 0x00 and 0x10 return 0. A read returns its data on bus_rdata in the clock cycle after bus_rd.
- R3: Select 0x00 holds an 8-bit ID in data bits 31:24. Select 0x01 reads 0x11 in bits 7:0 and NUM_PINS-1 in bits 23:16. Select 0x02 reads 0. Writes to selects 0x01 and 0x02 change nothing.
- R4: A select of 0x10 or more addresses entry (select-0x10)>>1. An even select accesses bits 31:0 and an odd select accesses bits 63:32. A write replaces only that half.
- R5: A select that maps to no register (0x03 to 0x0F, or an entry index of NUM_PINS or more) reads 0, and a write to it changes nothing.
- R6: A message carries the fields of the pin's entry: vector from bits 7:0, delivery mode from 10:8, destination mode from 11, polarity from 13, trigger from 15 (1 = level) and destination from 63:56.
- R7: A pin whose mask bit 16 is set emits nothing. A later write that clears the mask starts a pass that delivers the pin if it is still pending.
- R8: An edge pin (bit 15 = 0) becomes pending on a rising input. A falling input leaves it pending. Its delivery clears it, so a later pass emits nothing for it.
- R9: A level pin's pending bit follows the input. Delivery keeps it, so each later pass delivers it again while the input is high. Deassertion clears it.
- R10: Within a pass the scanner delivers pending, unmasked pins in ascending pin order, one message per pin.
- R11: While msg_valid is high and msg_ready is low, msg_valid and all message fields hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset, low 8 address bits |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_in | input | NUM_PINS | Interrupt input lines, active high |
| msg_valid | output | 1 | Delivery message valid |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_dest | output | 8 | Destination |
| msg_dest_mode | output | 1 | Destination mode |
| msg_dlv_mode | output | 3 | Delivery mode |
| msg_vector | output | 8 | Vector |
| msg_polarity | output | 1 | Polarity |
| msg_trigger | output | 1 | Trigger mode, 1 = level |

## Verification
The bench first walks a distinct arithmetic pattern through both halves of every entry. This separates the half-select and index decoding from the field routing. Next it fires each pin alone with its own field mix, which shows that every field reaches the message from its own bit position. Masked-then-unmasked pins and a release of the input before unmasking separate edge latching from level following. A level pin retriggered by entry writes shows that level pending survives delivery. Three pins asserted in the same cycle while ready is held low show the scan order and that the message holds during a stall.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam logic [7:0] OFF_SEL     = 8'h00;
  localparam logic [7:0] OFF_DATA    = 8'h10;
  localparam logic [7:0] SEL_ID      = 8'h00;
  localparam logic [7:0] SEL_VER     = 8'h01;
  localparam logic [7:0] SEL_ARB     = 8'h02;
  localparam logic [7:0] SEL_TAB     = 8'h10;
  localparam logic [7:0] VERSION     = 8'h11;
  localparam int         B_DLV       = 8;
  localparam int         B_DMODE     = 11;
  localparam int         B_POL       = 13;
  localparam int         B_TRIG      = 15;
  localparam int         B_MASK      = 16;
  localparam int         B_DEST      = 56;
  localparam logic [31:0] LO_RESET   = 32'h0001_0000;
  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_SEND} scan_st_t;
endpackage

// File: rtl/irq_router_regs.sv
module irq_router_regs
  import irq_router_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [7:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                entry_wr,
  input  logic [IDX_W-1:0]    scan_idx,
  output logic [63:0]         scan_entry,
  output logic [NUM_PINS-1:0] trig_level
);
  localparam logic [7:0] LAST_IDX = 8'(NUM_PINS - 1);

  logic [7:0]  sel_q;
  logic [7:0]  id_q;
  logic [31:0] tab_lo [NUM_PINS];
  logic [31:0] tab_hi [NUM_PINS];
  logic [7:0]  sel_off;
  logic [6:0]  ent_idx;
  logic        ent_ok;
  logic [IDX_W-1:0] ent_pin;
  logic [31:0] rd_mux;

  assign sel_off = sel_q - SEL_TAB;
  assign ent_idx = sel_off[7:1];
  assign ent_ok  = (sel_q >= SEL_TAB) && (int'(ent_idx) < NUM_PINS);
  assign ent_pin = ent_idx[IDX_W-1:0];

  always_comb begin
    rd_mux = '0;
    if (bus_addr == OFF_SEL) begin
      rd_mux = {24'h0, sel_q};
    end else if (bus_addr == OFF_DATA) begin
      if (sel_q == SEL_ID)       rd_mux = {id_q, 24'h0};
      else if (sel_q == SEL_VER) rd_mux = {8'h0, LAST_IDX, 8'h0, VERSION};
      else if (ent_ok)           rd_mux = sel_q[0] ? tab_hi[ent_pin] : tab_lo[ent_pin];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= '0;
      id_q      <= '0;
      bus_rdata <= '0;
      entry_wr  <= 1'b0;
      for (int i = 0; i < NUM_PINS; i++) begin
        tab_lo[i] <= LO_RESET;
        tab_hi[i] <= '0;
      end
    end else begin
      entry_wr <= 1'b0;
      if (bus_rd) bus_rdata <= rd_mux;
      if (bus_wr && bus_addr == OFF_SEL) begin
        sel_q <= bus_wdata[7:0];
      end else if (bus_wr && bus_addr == OFF_DATA) begin
        if (sel_q == SEL_ID) begin
          id_q <= bus_wdata[31:24];
        end else if (ent_ok) begin
          entry_wr <= 1'b1;
          if (sel_q[0]) tab_hi[ent_pin] <= bus_wdata;
          else          tab_lo[ent_pin] <= bus_wdata;
        end
      end
    end
  end

  assign scan_entry = {tab_hi[scan_idx], tab_lo[scan_idx]};

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_trig
    assign trig_level[g] = tab_lo[g][B_TRIG];
  end

  assert_version_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == OFF_DATA && sel_q == SEL_VER)
      |=> (bus_rdata == {8'h0, LAST_IDX, 8'h0, VERSION}));

  assert_unmapped_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == OFF_DATA && sel_q > SEL_ARB && sel_q < SEL_TAB)
      |=> (bus_rdata == 32'h0));

  assert_sel_readback_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == OFF_SEL && !bus_wr) |=> (bus_rdata[31:8] == 24'h0));
endmodule

// File: rtl/irq_router_pend.sv
module irq_router_pend #(
  parameter int NUM_PINS = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] irq_in,
  input  logic [NUM_PINS-1:0] trig_level,
  input  logic [NUM_PINS-1:0] clr,
  output logic [NUM_PINS-1:0] pend,
  output logic                rise_any
);
  logic [NUM_PINS-1:0] prev_q;
  logic [NUM_PINS-1:0] rise;

  assign rise     = irq_in & ~prev_q;
  assign rise_any = |rise;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= irq_in;
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst)                pend[g] <= 1'b0;
      else if (trig_level[g]) pend[g] <= irq_in[g];
      else                    pend[g] <= (pend[g] & ~clr[g]) | rise[g];
    end

    assert_level_follow_R9: assert property (@(posedge clk) disable iff (rst)
      ($past(trig_level[g]) && !$past(irq_in[g])) |-> !pend[g]);

    assert_edge_clear_R8: assert property (@(posedge clk) disable iff (rst)
      $past(clr[g] && !trig_level[g] && !rise[g]) |-> !pend[g]);
  end
endmodule

// File: rtl/irq_router_scan.sv
module irq_router_scan
  import irq_router_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pend,
  input  logic                entry_wr,
  input  logic                rise_any,
  input  logic [63:0]         scan_entry,
  output logic [IDX_W-1:0]    scan_idx,
  output logic [NUM_PINS-1:0] clr,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [7:0]          msg_dest,
  output logic                msg_dest_mode,
  output logic [2:0]          msg_dlv_mode,
  output logic [7:0]          msg_vector,
  output logic                msg_polarity,
  output logic                msg_trigger
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_PINS - 1);

  scan_st_t st_q;
  logic     req_q;
  logic     start;
  logic     hit;

  assign start = (st_q == S_IDLE) && req_q;
  assign hit   = (st_q == S_SCAN) && pend[scan_idx] && !scan_entry[B_MASK];
  assign clr   = hit ? (NUM_PINS'(1) << scan_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= S_IDLE;
      req_q         <= 1'b0;
      scan_idx      <= '0;
      msg_valid     <= 1'b0;
      msg_dest      <= '0;
      msg_dest_mode <= 1'b0;
      msg_dlv_mode  <= '0;
      msg_vector    <= '0;
      msg_polarity  <= 1'b0;
      msg_trigger   <= 1'b0;
    end else begin
      req_q <= (req_q & ~start) | entry_wr | rise_any;
      case (st_q)
        S_IDLE: if (req_q) begin
          st_q     <= S_SCAN;
          scan_idx <= '0;
        end
        S_SCAN: if (hit) begin
          msg_valid     <= 1'b1;
          msg_vector    <= scan_entry[7:0];
          msg_dlv_mode  <= scan_entry[B_DLV+:3];
          msg_dest_mode <= scan_entry[B_DMODE];
          msg_polarity  <= scan_entry[B_POL];
          msg_trigger   <= scan_entry[B_TRIG];
          msg_dest      <= scan_entry[B_DEST+:8];
          st_q          <= S_SEND;
        end else if (scan_idx == LAST) begin
          st_q <= S_IDLE;
        end else begin
          scan_idx <= scan_idx + 1'b1;
        end
        S_SEND: if (msg_ready) begin
          msg_valid <= 1'b0;
          if (scan_idx == LAST) begin
            st_q <= S_IDLE;
          end else begin
            st_q     <= S_SCAN;
            scan_idx <= scan_idx + 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assert_hold_stall_R11: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) && $stable(msg_dest)
      && $stable(msg_dlv_mode) && $stable(msg_trigger) && $stable(msg_dest_mode)
      && $stable(msg_polarity)));

  assert_pending_source_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_valid) |-> $past(pend[scan_idx]));
endmodule

// File: rtl/irq_router.sv
module irq_router #(
  parameter int NUM_PINS = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [7:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] irq_in,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [7:0]          msg_dest,
  output logic                msg_dest_mode,
  output logic [2:0]          msg_dlv_mode,
  output logic [7:0]          msg_vector,
  output logic                msg_polarity,
  output logic                msg_trigger
);
  localparam int IDX_W = $clog2(NUM_PINS);

  logic                entry_wr;
  logic [IDX_W-1:0]    scan_idx;
  logic [63:0]         scan_entry;
  logic [NUM_PINS-1:0] trig_level;
  logic [NUM_PINS-1:0] clr;
  logic [NUM_PINS-1:0] pend;
  logic                rise_any;

  irq_router_regs #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .entry_wr(entry_wr),
    .scan_idx(scan_idx), .scan_entry(scan_entry), .trig_level(trig_level));

  irq_router_pend #(.NUM_PINS(NUM_PINS)) u_pend (
    .clk(clk), .rst(rst), .irq_in(irq_in), .trig_level(trig_level), .clr(clr),
    .pend(pend), .rise_any(rise_any));

  irq_router_scan #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_scan (
    .clk(clk), .rst(rst), .pend(pend), .entry_wr(entry_wr), .rise_any(rise_any),
    .scan_entry(scan_entry), .scan_idx(scan_idx), .clr(clr),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest),
    .msg_dest_mode(msg_dest_mode), .msg_dlv_mode(msg_dlv_mode), .msg_vector(msg_vector),
    .msg_polarity(msg_polarity), .msg_trigger(msg_trigger));

  assert_reset_quiet_R1: assert property (@(posedge clk) $past(rst) |-> !msg_valid);
endmodule

// File: tb/irq_router_tb.sv
`timescale 1ns/1ps
module irq_router_tb;
  localparam int N = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] irq_in = '0;
  logic        msg_valid, msg_ready = 1'b1;
  logic [7:0]  msg_dest, msg_vector;
  logic        msg_dest_mode, msg_polarity, msg_trigger;
  logic [2:0]  msg_dlv_mode;

  int n_chk = 0, n_fail = 0, n_msg = 0;
  logic [7:0] log_vec  [256];
  logic [7:0] log_dest [256];
  logic [2:0] log_dlv  [256];
  logic       log_dm   [256];
  logic       log_pol  [256];
  logic       log_trg  [256];

  always #4 clk = ~clk;

  irq_router #(.NUM_PINS(N)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest),
    .msg_dest_mode(msg_dest_mode), .msg_dlv_mode(msg_dlv_mode), .msg_vector(msg_vector),
    .msg_polarity(msg_polarity), .msg_trigger(msg_trigger));

  always @(negedge clk) begin
    if (!rst && msg_valid && msg_ready && n_msg < 256) begin
      log_vec[n_msg]  = msg_vector;
      log_dest[n_msg] = msg_dest;
      log_dlv[n_msg]  = msg_dlv_mode;
      log_dm[n_msg]   = msg_dest_mode;
      log_pol[n_msg]  = msg_polarity;
      log_trg[n_msg]  = msg_trigger;
      n_msg++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic rd_sel(input logic [7:0] s, output logic [31:0] d);
    wr(8'h00, {24'h0, s});
    rd(8'h10, d);
  endtask

  task automatic wr_sel(input logic [7:0] s, input logic [31:0] d);
    wr(8'h00, {24'h0, s});
    wr(8'h10, d);
  endtask

  // high half first, low half (holding the mask) last
  task automatic wr_entry(input int p, input logic [31:0] lo, input logic [31:0] hi);
    wr_sel(8'(8'h11 + 2 * p), hi);
    wr_sel(8'(8'h10 + 2 * p), lo);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] lo_of(input logic [7:0] vec, input int dlv, input bit dm,
                                        input bit pol, input bit trg, input bit msk);
    return {15'h0, msk, trg, 1'b0, pol, 1'b0, dm, 3'(dlv), vec};
  endfunction

  initial begin
    #(8ns * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int base;
    idle(5);
    @(negedge clk); rst = 1'b0;
    idle(2);

    // R1 reset state
    check(msg_valid == 1'b0, "R1 no message", {31'h0, msg_valid}, 32'h0);
    rd(8'h00, d); check(d == 32'h0, "R1 select", d, 32'h0);
    rd(8'h10, d); check(d == 32'h0, "R1 id", d, 32'h0);
    for (int p = 0; p < N; p++) begin
      rd_sel(8'(8'h10 + 2 * p), d); check(d == 32'h0001_0000, "R1 entry low", d, 32'h0001_0000);
      rd_sel(8'(8'h11 + 2 * p), d); check(d == 32'h0, "R1 entry high", d, 32'h0);
    end

    // R2 select window and other offsets
    wr(8'h00, 32'hFFFF_FF5A); rd(8'h00, d); check(d == 32'h5A, "R2 select readback", d, 32'h5A);
    rd(8'h04, d); check(d == 32'h0, "R2 other offset", d, 32'h0);
    rd(8'h20, d); check(d == 32'h0, "R2 other offset", d, 32'h0);

    // R3 id, version, reserved
    wr_sel(8'h00, 32'hAB12_3456); rd_sel(8'h00, d); check(d == 32'hAB00_0000, "R3 id", d, 32'hAB00_0000);
    rd_sel(8'h01, d); check(d == 32'h0017_0011, "R3 version", d, 32'h0017_0011);
    wr_sel(8'h01, 32'hFFFF_FFFF); rd_sel(8'h01, d); check(d == 32'h0017_0011, "R3 version write ignored", d, 32'h0017_0011);
    wr_sel(8'h02, 32'hFFFF_FFFF); rd_sel(8'h02, d); check(d == 32'h0, "R3 select 2 zero", d, 32'h0);
    rd_sel(8'h00, d); check(d == 32'hAB00_0000, "R3 id kept", d, 32'hAB00_0000);

    // R4 half access sweep (all pins stay masked)
    for (int p = 0; p < N; p++) begin
      logic [31:0] lo, hi;
      lo = 32'h0001_0000 | (32'(p) * 32'h0000_0101) | 32'h4000_0000;
      hi = 32'(p + 1) * 32'h0103_0507;
      wr_entry(p, lo, hi);
      rd_sel(8'(8'h10 + 2 * p), d); check(d == lo, "R4 low half", d, lo);
      rd_sel(8'(8'h11 + 2 * p), d); check(d == hi, "R4 high half", d, hi);
      wr_sel(8'(8'h11 + 2 * p), ~hi);
      rd_sel(8'(8'h10 + 2 * p), d); check(d == lo, "R4 low untouched", d, lo);
    end

    // R5 unmapped selects
    wr_sel(8'h40, 32'hFFFF_FFFF); rd_sel(8'h40, d); check(d == 32'h0, "R5 index 24 low", d, 32'h0);
    rd_sel(8'h41, d); check(d == 32'h0, "R5 index 24 high", d, 32'h0);
    rd_sel(8'h3E, d); check(d == 32'h4001_1717, "R5 last entry unchanged", d, 32'h4001_1717);
    wr_sel(8'h05, 32'hFFFF_FFFF); rd_sel(8'h05, d); check(d == 32'h0, "R5 select 5", d, 32'h0);
    rd_sel(8'hFF, d); check(d == 32'h0, "R5 select FF", d, 32'h0);
    check(n_msg == 0, "R7 masked pins silent", 32'(n_msg), 32'h0);

    // R6 / R8 field sweep: one edge pin at a time
    for (int p = 0; p < N; p++) begin
      logic [7:0] vec, dst;
      vec = 8'(8'h20 + p); dst = 8'(8'hF0 ^ p);
      base = n_msg;
      wr_entry(p, lo_of(vec, p % 8, p[0], p[1], 1'b0, 1'b0), {dst, 24'h0});
      idle(40);
      @(negedge clk); irq_in[p] = 1'b1;
      idle(2); irq_in[p] = 1'b0;
      idle(40);
      check(n_msg == base + 1, "R8 one message per edge", 32'(n_msg - base), 32'h1);
      if (n_msg > base) begin
        check(log_vec[base] == vec, "R6 vector", 32'(log_vec[base]), 32'(vec));
        check(log_dest[base] == dst, "R6 dest", 32'(log_dest[base]), 32'(dst));
        check(log_dlv[base] == 3'(p % 8), "R6 delivery mode", 32'(log_dlv[base]), 32'(p % 8));
        check(log_dm[base] == p[0] && log_pol[base] == p[1] && log_trg[base] == 1'b0,
              "R6 mode/polarity/trigger", {29'h0, log_dm[base], log_pol[base], log_trg[base]},
              {29'h0, p[0], p[1], 1'b0});
      end
    end
    base = n_msg;
    wr_entry(0, lo_of(8'h20, 0, 1'b0, 1'b0, 1'b0, 1'b0), 32'h0);
    idle(60);
    check(n_msg == base, "R8 delivered edge cleared", 32'(n_msg - base), 32'h0);

    // R7 / R8 masked edge pin released before unmask
    base = n_msg;
    wr_entry(9, lo_of(8'h40, 0, 1'b0, 1'b0, 1'b0, 1'b1), 32'h0);
    @(negedge clk); irq_in[9] = 1'b1; idle(3); irq_in[9] = 1'b0;
    idle(60);
    check(n_msg == base, "R7 masked no message", 32'(n_msg - base), 32'h0);
    wr_sel(8'h22, lo_of(8'h40, 0, 1'b0, 1'b0, 1'b0, 1'b0));
    idle(60);
    check(n_msg == base + 1, "R8 deassert kept pending", 32'(n_msg - base), 32'h1);
    if (n_msg > base) check(log_vec[base] == 8'h40, "R7 unmask delivers", 32'(log_vec[base]), 32'h40);

    // R9 level pin
    base = n_msg;
    wr_entry(5, lo_of(8'h55, 0, 1'b0, 1'b0, 1'b1, 1'b0), 32'h0);
    idle(40);
    @(negedge clk); irq_in[5] = 1'b1;
    idle(60);
    check(n_msg == base + 1, "R9 level delivered", 32'(n_msg - base), 32'h1);
    if (n_msg > base) check(log_trg[base] == 1'b1, "R9 trigger level", 32'(log_trg[base]), 32'h1);
    wr_sel(8'h1B, 32'h7700_0000);
    idle(60);
    check(n_msg == base + 2, "R9 level kept pending", 32'(n_msg - base), 32'h2);
    if (n_msg > base + 1) check(log_dest[base+1] == 8'h77, "R9 redelivery dest", 32'(log_dest[base+1]), 32'h77);
    @(negedge clk); irq_in[5] = 1'b0;
    idle(60);
    base = n_msg;
    wr_sel(8'h1B, 32'h6600_0000);
    idle(60);
    check(n_msg == base, "R9 deassert clears", 32'(n_msg - base), 32'h0);

    // R10 / R11 scan order under stall
    wr_entry(3,  lo_of(8'h83, 1, 1'b0, 1'b0, 1'b0, 1'b0), 32'h0);
    wr_entry(7,  lo_of(8'h87, 2, 1'b0, 1'b0, 1'b0, 1'b0), 32'h0);
    wr_entry(20, lo_of(8'h94, 3, 1'b0, 1'b0, 1'b0, 1'b0), 32'h0);
    idle(60);
    base = n_msg;
    @(negedge clk); msg_ready = 1'b0; irq_in[20] = 1'b1; irq_in[7] = 1'b1; irq_in[3] = 1'b1;
    idle(20);
    check(msg_valid && msg_vector == 8'h83, "R10 lowest pin first", {24'h0, msg_vector}, 32'h83);
    idle(15);
    check(msg_valid && msg_vector == 8'h83 && msg_dlv_mode == 3'd1, "R11 held during stall",
          {24'h0, msg_vector}, 32'h83);
    @(negedge clk); msg_ready = 1'b1; irq_in = '0;
    idle(80);
    check(n_msg == base + 3, "R10 one per pin", 32'(n_msg - base), 32'h3);
    if (n_msg >= base + 3) begin
      check(log_vec[base+1] == 8'h87, "R10 second pin", 32'(log_vec[base+1]), 32'h87);
      check(log_vec[base+2] == 8'h94, "R10 third pin", 32'(log_vec[base+2]), 32'h94);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule